// File: doc/BRIEF.md
# Four-Lane Time-Interleaved ALU

This block keeps a full-rate stream of ALU operations flowing through four slower copies of the same combinational ALU. One operation can enter on every clock. A free-running two-bit phase counter steers each operation into one of four lane registers. Each lane therefore captures new operands once in every four cycles, and its combinational logic has four full cycles to settle.

A four-way multiplexer, driven by the same phase counter, picks the lane whose result is due on that cycle. A shared output register running at the full clock rate captures it. The result stream leaves in the order the operations arrived, at one result per cycle, after a fixed latency.

The lane clocks are modelled as one-hot load enables inside a single clock domain. An input-valid qualifier travels alongside each operation, so idle cycles come out as idle output cycles.

Top module: `ilv_alu_quad`

## Requirements
- R1: Opcode encoding of `in_op`: 0 adds, 1 subtracts (a minus b), 2 is AND, 3 is OR, 4 is XOR, 5 is NOR, 6 is NAND, 7 passes a, 8 passes b, 9 gives 1 when a equals b (else 0), and 10 gives 1 when they differ (else 0). The result is DATA_W bits wide.
- R2: `out_cy` is the carry out of the addition. For subtraction it is the borrow, set when a is less than b as unsigned values. It is 0 for every other opcode. `out_zf` is 1 exactly when the valid result is all zeros.
- R3: Opcodes 11 to 15 give a zero result, `out_cy` low and `out_zf` high.
- R4: The lane index is a phase value that starts at 0 after reset and steps 0, 1, 2, 3, 0 once per clock. Exactly one lane loads on each clock. An operation sampled while the phase is k is held in lane k.
- R5: An operation sampled on clock edge n appears on the outputs right after edge n+4, with `out_vld` high. Results leave in input order, one per cycle.
- R6: An edge on which `in_vld` is low produces, four edges later, an output cycle with `out_vld`, `out_res`, `out_cy` and `out_zf` all 0.
- R7: While `rst_n` is low, and for the first four edges after it rises, every output is 0.
- R8: A lane's captured operation and valid bit stay unchanged on every edge where that lane is not loading.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Full-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | An operation is present this cycle |
| in_op | input | 4 | Opcode (see R1) |
| in_a | input | DATA_W | First operand |
| in_b | input | DATA_W | Second operand |
| out_vld | output | 1 | Output holds a result |
| out_res | output | DATA_W | Result |
| out_cy | output | 1 | Carry or borrow flag |
| out_zf | output | 1 | Zero-result flag |

## Verification
The hardest case to reach is an idle cycle landing in one particular lane while the other three lanes hold live operations. Such a bubble must not disturb their results or shift the stream. The stimulus inserts idle cycles at periods of 2, 3, 4 and 5. This makes the gaps rotate through every phase alignment. A long random run with sparse idle cycles follows. Back-to-back operations of different opcodes make each lane hold its own operands through the three cycles in which its neighbours load.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_AND   = 4'd2,
    OP_OR    = 4'd3,
    OP_XOR   = 4'd4,
    OP_NOR   = 4'd5,
    OP_NAND  = 4'd6,
    OP_PASSA = 4'd7,
    OP_PASSB = 4'd8,
    OP_EQ    = 4'd9,
    OP_NE    = 4'd10
  } alu_op_e;
endpackage

// File: rtl/ilv_phase_ctr.sv
module ilv_phase_ctr #(
  parameter int unsigned LANES = 4,
  localparam int unsigned PH_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [PH_W-1:0]  phase,
  output logic [LANES-1:0] lane_ld
);
  localparam logic [PH_W-1:0] LAST = PH_W'(LANES - 1);

  // R4: the phase steps once per clock and wraps after the last lane
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= '0;
    else        phase <= (phase == LAST) ? '0 : phase + 1'b1;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_ld
    assign lane_ld[k] = (phase == PH_W'(k));
  end
endmodule

// File: rtl/ilv_lane.sv
module ilv_lane #(
  parameter int unsigned DATA_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ld,
  input  logic                    in_vld,
  input  logic [ilv_pkg::OP_W-1:0] in_op,
  input  logic [DATA_W-1:0]       in_a,
  input  logic [DATA_W-1:0]       in_b,
  output logic                    vld_q,
  output logic [DATA_W-1:0]       res,
  output logic                    cy,
  output logic                    zf
);
  import ilv_pkg::*;

  logic [OP_W-1:0]   op_q;
  logic [DATA_W-1:0] a_q, b_q;

  // Returns {carry, result, zero}
  function automatic logic [DATA_W+1:0] alu_eval(
    input logic [OP_W-1:0]   op,
    input logic [DATA_W-1:0] a,
    input logic [DATA_W-1:0] b
  );
    logic [DATA_W:0] w;
    w = '0;
    case (op)
      OP_ADD:   w = {1'b0, a} + {1'b0, b};
      OP_SUB:   w = {1'b0, a} - {1'b0, b};
      OP_AND:   w = {1'b0, a & b};
      OP_OR:    w = {1'b0, a | b};
      OP_XOR:   w = {1'b0, a ^ b};
      OP_NOR:   w = {1'b0, ~(a | b)};
      OP_NAND:  w = {1'b0, ~(a & b)};
      OP_PASSA: w = {1'b0, a};
      OP_PASSB: w = {1'b0, b};
      OP_EQ:    w = {{DATA_W{1'b0}}, (a == b)};
      OP_NE:    w = {{DATA_W{1'b0}}, (a != b)};
      default:  w = '0;
    endcase
    return {w, (w[DATA_W-1:0] == '0)};
  endfunction

  // R8: the lane register changes only on its own load enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      op_q  <= '0;
      a_q   <= '0;
      b_q   <= '0;
    end else if (ld) begin
      vld_q <= in_vld;
      op_q  <= in_op;
      a_q   <= in_a;
      b_q   <= in_b;
    end
  end

  assign {cy, res, zf} = alu_eval(op_q, a_q, b_q);
endmodule

// File: rtl/ilv_out_stage.sv
module ilv_out_stage #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LANES  = 4,
  localparam int unsigned PH_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [PH_W-1:0]              phase,
  input  logic [LANES-1:0]             lane_vld,
  input  logic [LANES-1:0][DATA_W-1:0] lane_res,
  input  logic [LANES-1:0]             lane_cy,
  input  logic [LANES-1:0]             lane_zf,
  output logic                         sel_vld,
  output logic                         out_vld,
  output logic [DATA_W-1:0]            out_res,
  output logic                         out_cy,
  output logic                         out_zf
);
  logic [DATA_W-1:0] sel_res;
  logic              sel_cy, sel_zf;

  // The lane due this cycle is the one about to be reloaded
  always_comb begin
    sel_vld = lane_vld[phase];
    sel_res = lane_res[phase];
    sel_cy  = lane_cy[phase];
    sel_zf  = lane_zf[phase];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      out_res <= '0;
      out_cy  <= 1'b0;
      out_zf  <= 1'b0;
    end else if (sel_vld) begin
      out_vld <= 1'b1;
      out_res <= sel_res;
      out_cy  <= sel_cy;
      out_zf  <= sel_zf;
    end else begin
      // R6: idle slots leave a clean all-zero output
      out_vld <= 1'b0;
      out_res <= '0;
      out_cy  <= 1'b0;
      out_zf  <= 1'b0;
    end
  end
endmodule

// File: rtl/ilv_alu_quad.sv
module ilv_alu_quad #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LANES  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_vld,
  input  logic [ilv_pkg::OP_W-1:0] in_op,
  input  logic [DATA_W-1:0]        in_a,
  input  logic [DATA_W-1:0]        in_b,
  output logic                     out_vld,
  output logic [DATA_W-1:0]        out_res,
  output logic                     out_cy,
  output logic                     out_zf
);
  localparam int unsigned PH_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic [PH_W-1:0]              phase;
  logic [LANES-1:0]             lane_ld;
  logic [LANES-1:0]             lane_vld;
  logic [LANES-1:0][DATA_W-1:0] lane_res;
  logic [LANES-1:0]             lane_cy;
  logic [LANES-1:0]             lane_zf;
  logic                         sel_vld;

  ilv_phase_ctr #(.LANES(LANES)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase   (phase),
    .lane_ld (lane_ld)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    ilv_lane #(.DATA_W(DATA_W)) u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (lane_ld[k]),
      .in_vld (in_vld),
      .in_op  (in_op),
      .in_a   (in_a),
      .in_b   (in_b),
      .vld_q  (lane_vld[k]),
      .res    (lane_res[k]),
      .cy     (lane_cy[k]),
      .zf     (lane_zf[k])
    );
  end

  ilv_out_stage #(.DATA_W(DATA_W), .LANES(LANES)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase    (phase),
    .lane_vld (lane_vld),
    .lane_res (lane_res),
    .lane_cy  (lane_cy),
    .lane_zf  (lane_zf),
    .sel_vld  (sel_vld),
    .out_vld  (out_vld),
    .out_res  (out_res),
    .out_cy   (out_cy),
    .out_zf   (out_zf)
  );
endmodule

// File: rtl/ilv_alu_quad_chk.sv
module ilv_alu_quad_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LANES  = 4,
  localparam int unsigned PH_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PH_W-1:0]   phase,
  input logic [LANES-1:0]  lane_ld,
  input logic [LANES-1:0]  lane_vld,
  input logic              sel_vld,
  input logic              in_vld,
  input logic              out_vld,
  input logic [DATA_W-1:0] out_res,
  input logic              out_cy,
  input logic              out_zf
);
  localparam int unsigned CNT_W = $clog2(LANES + 3) + 1;
  localparam logic [CNT_W-1:0] FILL = CNT_W'(LANES + 1);

  logic [CNT_W-1:0] since_rst;
  logic [LANES:0]   vld_hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= '0;
      vld_hist  <= '0;
    end else begin
      if (since_rst < FILL) since_rst <= since_rst + 1'b1;
      vld_hist <= {vld_hist[LANES-1:0], in_vld};
    end
  end

  assert_phase_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> phase == (($past(phase) == PH_W'(LANES - 1)) ? '0 : PH_W'($past(phase) + 1'b1)));

  assert_one_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lane_ld) == 1);

  for (genvar k = 0; k < LANES; k++) begin : g_hold
    assert_lane_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !lane_ld[k] |=> $stable(lane_vld[k]));
  end

  assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld == vld_hist[LANES]);

  assert_select_to_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_vld |=> out_vld);

  assert_fill_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    since_rst < FILL |-> !out_vld);

  assert_bubble_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> (out_res == '0 && !out_cy && !out_zf));

  assert_zero_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> out_zf == (out_res == '0));
endmodule

bind ilv_alu_quad ilv_alu_quad_chk #(.DATA_W(DATA_W), .LANES(LANES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .phase    (phase),
  .lane_ld  (lane_ld),
  .lane_vld (lane_vld),
  .sel_vld  (sel_vld),
  .in_vld   (in_vld),
  .out_vld  (out_vld),
  .out_res  (out_res),
  .out_cy   (out_cy),
  .out_zf   (out_zf)
);

// File: tb/test_ilv_alu_quad.sv
module test_ilv_alu_quad;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int LAT = 4;

  typedef struct packed {
    logic          vld;
    logic [3:0]    op;
    logic [DW-1:0] res;
    logic          cy;
    logic          zf;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_vld = 1'b0;
  logic [3:0]    in_op = '0;
  logic [DW-1:0] in_a = '0;
  logic [DW-1:0] in_b = '0;
  logic          out_vld;
  logic [DW-1:0] out_res;
  logic          out_cy;
  logic          out_zf;

  item_t sb[$];
  int    n_chk = 0;
  int    n_bad = 0;
  int    edge_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ilv_alu_quad #(.DATA_W(DW), .LANES(4)) i_ilv_alu_quad (
    .clk (clk), .rst_n (rst_n), .in_vld (in_vld), .in_op (in_op),
    .in_a (in_a), .in_b (in_b), .out_vld (out_vld), .out_res (out_res),
    .out_cy (out_cy), .out_zf (out_zf)
  );

  // Single-operation reference, written from the requirements
  function automatic item_t model(bit v, bit [3:0] op, bit [DW-1:0] a, bit [DW-1:0] b);
    item_t it;
    bit [DW:0] wide;
    it = '0;
    it.op = op;
    if (!v) return it;                        // R6: idle slot is all zero
    it.vld = 1'b1;
    case (op)
      4'd0: begin wide = {1'b0, a} + {1'b0, b}; it.res = wide[DW-1:0]; it.cy = wide[DW]; end
      4'd1: begin it.res = a - b; it.cy = (a < b); end
      4'd2: it.res = a & b;
      4'd3: it.res = a | b;
      4'd4: it.res = a ^ b;
      4'd5: it.res = ~(a | b);
      4'd6: it.res = ~(a & b);
      4'd7: it.res = a;
      4'd8: it.res = b;
      4'd9: it.res = (a == b) ? DW'(1) : DW'(0);
      4'd10: it.res = (a != b) ? DW'(1) : DW'(0);
      default: it.res = '0;                   // R3
    endcase
    it.zf = (it.res == '0);
    return it;
  endfunction

  // Driver: drives at the current falling edge, records expectation, moves on
  task automatic push_op(bit v, bit [3:0] op, bit [DW-1:0] a, bit [DW-1:0] b);
    in_vld = v;
    in_op  = op;
    in_a   = a;
    in_b   = b;
    sb.push_back(model(v, op, a, b));
    @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  // Monitor: samples a quarter period after each rising edge
  initial begin
    item_t e;
    string tag;
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (rst_n) begin
        edge_cnt++;
        if (edge_cnt <= LAT) begin
          n_chk++;
          if (out_vld !== 1'b0 || out_res !== '0 || out_cy !== 1'b0 || out_zf !== 1'b0) begin
            n_bad++;
            $display("FAIL R7 fill edge %0d got vld=%0b res=%h cy=%0b zf=%0b exp all 0",
                     edge_cnt, out_vld, out_res, out_cy, out_zf);
          end
        end
        if (sb.size() == LAT + 1) begin
          e = sb.pop_front();
          n_chk++;
          if (out_vld !== e.vld || out_res !== e.res || out_cy !== e.cy || out_zf !== e.zf) begin
            if (out_vld !== e.vld)      tag = e.vld ? "R5" : "R6";
            else if (!e.vld)            tag = "R6";
            else if (e.op > 4'd10)      tag = "R3";
            else if (out_res !== e.res) tag = "R1";
            else                        tag = "R2";
            n_bad++;
            $display("FAIL %s op=%0d got vld=%0b res=%h cy=%0b zf=%0b exp vld=%0b res=%h cy=%0b zf=%0b",
                     tag, e.op, out_vld, out_res, out_cy, out_zf, e.vld, e.res, e.cy, e.zf);
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7: outputs cleared while reset is held
    n_chk++;
    if (out_vld !== 1'b0 || out_res !== '0 || out_cy !== 1'b0 || out_zf !== 1'b0) begin
      n_bad++;
      $display("FAIL R7 reset got vld=%0b res=%h cy=%0b zf=%0b exp all 0",
               out_vld, out_res, out_cy, out_zf);
    end
    rst_n = 1'b1;

    // R1 and R2 corners
    push_op(1, 4'd0, 16'hFFFF, 16'h0001);   // wraps to 0, carry, zero
    push_op(1, 4'd0, 16'h1234, 16'h1111);
    push_op(1, 4'd1, 16'h0005, 16'h0007);   // borrow
    push_op(1, 4'd1, 16'h0009, 16'h0009);   // zero, no borrow
    push_op(1, 4'd2, 16'hF0F0, 16'h3C3C);
    push_op(1, 4'd3, 16'hF000, 16'h000F);
    push_op(1, 4'd4, 16'hAAAA, 16'hAAAA);
    push_op(1, 4'd5, 16'hFFFF, 16'h0000);
    push_op(1, 4'd6, 16'hFFFF, 16'hFFFF);
    push_op(1, 4'd7, 16'hBEEF, 16'h1234);
    push_op(1, 4'd8, 16'hBEEF, 16'h1234);
    push_op(1, 4'd9, 16'h5555, 16'h5555);
    push_op(1, 4'd9, 16'h5555, 16'h5556);
    push_op(1, 4'd10, 16'h5555, 16'h5555);
    push_op(1, 4'd10, 16'h0000, 16'h8000);
    // R3: undefined opcodes
    for (int op = 11; op < 16; op++) push_op(1, 4'(op), 16'hFFFF, 16'h7FFF);

    // R4 and R8: back-to-back distinct ops rotate through every lane, order preserved
    for (int i = 0; i < 64; i++)
      push_op(1, 4'(i % 11), 16'(i * 16'h0101), 16'(16'hFFFF - i * 3));

    // R6: idle slots at periods 2..5 so they land in every lane
    for (int per = 2; per <= 5; per++)
      for (int i = 0; i < 40; i++)
        push_op((i % per) != 0, 4'(i % 16), 16'($urandom), 16'($urandom));

    // Mixed random stream
    for (int i = 0; i < 400; i++)
      push_op(($urandom % 10) != 0, 4'($urandom % 16), 16'($urandom), 16'($urandom));

    // flush
    for (int i = 0; i <= LAT; i++) push_op(0, 4'd0, '0, '0);
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule